// File: doc/BRIEF.md
# Two-Pin Mode and Interrupt Controller

This block governs the two general-purpose pins of a small sensor peripheral. A setup register holds one 2-bit mode field per pin, and an enable register selects which status flags may raise an interrupt. Pin 0 can act as an open-drain, active-low interrupt output. Pin 1 can act as an active-low input whose falling edge starts a conversion. In any mode, the synchronized pin levels can be latched as the two lowest bits of the 7-bit bus address. A mode that switches on the internal pull-down forces that address bit to 0.

Register accesses use a plain single-cycle port. A write completes at the clock edge where `wr_en_i` is high. A read is combinational from `rd_addr_i`. No pin or register signal uses valid/ready, so there is no back-pressure. Status flags are level inputs that the block samples on every cycle. The conversion request is a one-clock strobe. The bus logic pulses `strap_sample_i` at each start condition to latch the address bits. The serial bus protocol and the pad circuitry sit outside this block.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, both mode fields hold 10 (strap input), so the setup register (address 0x20) reads 0x82. The enable register (address 0x01) reads 0, no pad output enable is set, no pull-down is on, and the latched bus address is {STRAP_HI, 2'b00}.
- R2: A write to address 0x20 stores bits [1:0] as the pin 0 mode and bits [7:6] as the pin 1 mode. Bits [5:2] of that register read as 0. A read of any address other than 0x01 or 0x20 returns 0.
- R3: A write to address 0x01 stores the interrupt-enable mask, one bit per status flag. Reading it back returns the stored mask.
- R4: With pin 0 in mode 11, `pad_oe_o[0]` is 1 in the cycle after any status flag that is also enabled reads 1, and 0 in the cycle after no such flag is set.
- R5: With pin 0 in any mode other than 11, `pad_oe_o[0]` stays 0 whatever the status flags hold.
- R6: Pin 1 is never driven: `pad_oe_o[1]` is always 0.
- R7: `pad_pd_o[i]` is 1 exactly when pin i is in mode 01 or 11. In mode 00 or 10 it is 0.
- R8: With pin 1 in mode 11, a high-to-low transition on pin 1 produces exactly one `conv_start_o` pulse, one clock wide. Holding the pin low or raising it produces no further pulse.
- R9: With pin 1 in any mode other than 11, falling edges on pin 1 produce no `conv_start_o` pulse.
- R10: On a cycle with `strap_sample_i` high, `bus_addr_o` becomes {STRAP_HI, s1, s0} on the next clock. Here si is the synchronized level of pin i, forced to 0 when pin i has its pull-down on. The latched value holds until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| status_i | input | N_FLAGS | Status flag levels |
| pin_i | input | 2 | Pad input levels, pin 0 in bit 0 |
| pad_oe_o | output | 2 | Pad output enable; an enabled pad drives low |
| pad_pd_o | output | 2 | Internal pull-down enable per pad |
| conv_start_o | output | 1 | One-clock conversion request |
| strap_sample_i | input | 1 | Latch the address-strap bits (start condition) |
| bus_addr_o | output | 7 | Latched 7-bit bus address |

## Verification
Several rules are checked by assertions on every cycle: the interrupt follows the enabled flags one cycle later in mode 11 and stays released in other modes, pin 1 is never driven, conversion pulses are one cycle wide and appear only with pin 1 in mode 11, and a pulled-down pin always latches a 0 address bit. Only the bench scenarios can show the rest. These are the register contents and read-back masking, the exact count of conversion pulses for a given pin waveform, the absence of pulses from rising edges or a pin held low, and the full address value built from the synchronized pin levels.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  typedef enum logic [1:0] {
    PM_HIZ   = 2'b00,
    PM_PULL  = 2'b01,
    PM_STRAP = 2'b10,
    PM_FUNC  = 2'b11
  } pin_mode_e;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;
  localparam logic [REG_AW-1:0] REG_INT_EN = 8'h01;
  localparam logic [REG_AW-1:0] REG_SETUP  = 8'h20;
  localparam int unsigned PIN0_LSB = 0;
  localparam int unsigned PIN1_LSB = 6;
  localparam pin_mode_e RESET_MODE = PM_STRAP;

  function automatic logic mode_pulls_down(input pin_mode_e m);
    return (m == PM_PULL) || (m == PM_FUNC);
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pin_pkg::*;
#(
  parameter int unsigned N_FLAGS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    wr_addr_i,
  input  logic [REG_DW-1:0]    wr_data_i,
  input  logic [REG_AW-1:0]    rd_addr_i,
  output logic [REG_DW-1:0]    rd_data_o,
  output pin_mode_e            mode0_o,
  output pin_mode_e            mode1_o,
  output logic [N_FLAGS-1:0]   int_en_o
);
  pin_mode_e          mode0_q, mode1_q;
  logic [N_FLAGS-1:0] int_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode0_q  <= RESET_MODE;
      mode1_q  <= RESET_MODE;
      int_en_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_SETUP) begin
        mode0_q <= pin_mode_e'(wr_data_i[PIN0_LSB +: 2]);
        mode1_q <= pin_mode_e'(wr_data_i[PIN1_LSB +: 2]);
      end
      if (wr_addr_i == REG_INT_EN) begin
        int_en_q <= wr_data_i[N_FLAGS-1:0];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == REG_SETUP) begin
      rd_data_o[PIN0_LSB +: 2] = mode0_q;
      rd_data_o[PIN1_LSB +: 2] = mode1_q;
    end else if (rd_addr_i == REG_INT_EN) begin
      rd_data_o[N_FLAGS-1:0] = int_en_q;
    end
  end

  assign mode0_o  = mode0_q;
  assign mode1_o  = mode1_q;
  assign int_en_o = int_en_q;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned N_PINS = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] level_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
    end
    assign level_o[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen
  import gpio_pin_pkg::*;
#(
  parameter int unsigned N_FLAGS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pin_mode_e          mode_i,
  input  logic [N_FLAGS-1:0] status_i,
  input  logic [N_FLAGS-1:0] int_en_i,
  output logic               drive_low_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (mode_i == PM_FUNC) && (|(status_i & int_en_i));
  end
  assign drive_low_o = irq_q;
endmodule

// File: rtl/gpio_conv_trig.sv
module gpio_conv_trig
  import gpio_pin_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      level_i,
  output logic      start_o
);
  logic prev_q, start_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      prev_q  <= level_i;
      start_q <= (mode_i == PM_FUNC) && prev_q && !level_i;
    end
  end
  assign start_o = start_q;
endmodule

// File: rtl/gpio_strap_latch.sv
module gpio_strap_latch #(
  parameter int unsigned N_PINS  = 2,
  parameter int unsigned ADDR_W  = 7,
  parameter logic [ADDR_W-N_PINS-1:0] STRAP_HI = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [N_PINS-1:0] level_i,
  input  logic [N_PINS-1:0] pulled_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [N_PINS-1:0] bits_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bits_q <= '0;
    else if (sample_i) bits_q <= level_i & ~pulled_i;
  end
  assign addr_o = {STRAP_HI, bits_q};
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int unsigned N_FLAGS     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [4:0]  STRAP_HI    = 5'b10100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [7:0]         rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic [N_FLAGS-1:0] status_i,
  input  logic [1:0]         pin_i,
  output logic [1:0]         pad_oe_o,
  output logic [1:0]         pad_pd_o,
  output logic               conv_start_o,
  input  logic               strap_sample_i,
  output logic [6:0]         bus_addr_o
);
  localparam int unsigned N_PINS = 2;

  pin_mode_e          mode0, mode1;
  logic [N_FLAGS-1:0] int_en;
  logic [N_PINS-1:0]  level;
  logic [N_PINS-1:0]  pulled;
  logic               irq_drive;

  gpio_cfg_regs #(.N_FLAGS(N_FLAGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .mode0_o(mode0), .mode1_o(mode1), .int_en_o(int_en)
  );

  gpio_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .level_o(level)
  );

  gpio_irq_gen #(.N_FLAGS(N_FLAGS)) u_irq (
    .clk_i, .rst_ni, .mode_i(mode0), .status_i, .int_en_i(int_en),
    .drive_low_o(irq_drive)
  );

  gpio_conv_trig u_conv (
    .clk_i, .rst_ni, .mode_i(mode1), .level_i(level[1]), .start_o(conv_start_o)
  );

  assign pulled[0] = mode_pulls_down(mode0);
  assign pulled[1] = mode_pulls_down(mode1);

  gpio_strap_latch #(.N_PINS(N_PINS), .ADDR_W(7), .STRAP_HI(STRAP_HI)) u_strap (
    .clk_i, .rst_ni, .sample_i(strap_sample_i), .level_i(level),
    .pulled_i(pulled), .addr_o(bus_addr_o)
  );

  assign pad_oe_o = {1'b0, irq_drive};
  assign pad_pd_o = pulled;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
  import gpio_pin_pkg::*;
#(
  parameter int unsigned N_FLAGS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input pin_mode_e          mode0,
  input pin_mode_e          mode1,
  input logic [N_FLAGS-1:0] int_en,
  input logic [N_FLAGS-1:0] status_i,
  input logic [1:0]         pad_oe_o,
  input logic [1:0]         pad_pd_o,
  input logic               conv_start_o,
  input logic               strap_sample_i,
  input logic [6:0]         bus_addr_o
);
  // R4
  irq_follows_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode0 == PM_FUNC && |(status_i & int_en)) |=> pad_oe_o[0]);
  // R5
  irq_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode0 != PM_FUNC) |=> !pad_oe_o[0]);
  // R6
  pin1_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[1]);
  // R8
  conv_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R9
  conv_mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(mode1) == PM_FUNC);
  // R10
  strap_pulled_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_sample_i && pad_pd_o[0]) |=> !bus_addr_o[0]);
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.N_FLAGS(N_FLAGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode0(mode0), .mode1(mode1), .int_en(int_en),
  .status_i(status_i), .pad_oe_o(pad_oe_o), .pad_pd_o(pad_pd_o),
  .conv_start_o(conv_start_o), .strap_sample_i(strap_sample_i),
  .bus_addr_o(bus_addr_o)
);

// File: tb/gpio_pin_ctrl_tb.sv
module gpio_pin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] status = '0;
  logic [1:0] pin = 2'b11;
  logic [1:0] pad_oe, pad_pd;
  logic       conv;
  logic       strap = 1'b0;
  logic [6:0] bus_addr;
  int n_chk = 0, n_bad = 0, pulses = 0;
  localparam logic [4:0] HI = 5'b10100;

  always #4 clk = ~clk;

  gpio_pin_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .status_i(status), .pin_i(pin), .pad_oe_o(pad_oe), .pad_pd_o(pad_pd),
    .conv_start_o(conv), .strap_sample_i(strap), .bus_addr_o(bus_addr)
  );

  always @(negedge clk) if (conv) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 setup", 8'h20, 8'h82);
    rd_chk("R1 enable", 8'h01, 8'h00);
    check("R1 oe", pad_oe, 2'b00);
    check("R1 pd", pad_pd, 2'b00);
    check("R1 addr", bus_addr, {HI, 2'b00});
  endtask

  task automatic t_regs();
    wr(8'h20, 8'hFF);
    rd_chk("R2 setup masked", 8'h20, 8'hC3);
    check("R7 pd both", pad_pd, 2'b11);
    wr(8'h20, 8'h41);
    rd_chk("R2 split fields", 8'h20, 8'h41);
    check("R7 pd mode01/01", pad_pd, 2'b11);
    wr(8'h20, 8'h00);
    check("R7 pd mode00", pad_pd, 2'b00);
    rd_chk("R2 other addr", 8'h10, 8'h00);
    wr(8'h01, 8'hA5);
    rd_chk("R3 enable", 8'h01, 8'hA5);
    wr(8'h01, 8'h3C);
    rd_chk("R3 enable rewrite", 8'h01, 8'h3C);
  endtask

  task automatic t_irq();
    wr(8'h01, 8'h05);
    wr(8'h20, 8'h83);
    status = 8'h02; step(1);
    check("R4 unenabled flag", pad_oe[0], 1'b0);
    status = 8'h04; step(1);
    check("R4 enabled flag", pad_oe[0], 1'b1);
    check("R6 pin1 idle", pad_oe[1], 1'b0);
    status = 8'h00; step(1);
    check("R4 flag cleared", pad_oe[0], 1'b0);
    status = 8'h01; step(1);
    check("R4 bit0 flag", pad_oe[0], 1'b1);
    wr(8'h20, 8'h82); step(1);
    check("R5 mode10 released", pad_oe[0], 1'b0);
    wr(8'h20, 8'h81); status = 8'hFF; step(2);
    check("R5 mode01 released", pad_oe[0], 1'b0);
    status = 8'h00;
  endtask

  task automatic t_conv();
    wr(8'h20, 8'hC0);
    pin[1] = 1'b1; step(4); pulses = 0;
    pin[1] = 1'b0; step(6);
    check("R8 one pulse on fall", pulses, 1);
    step(6);
    check("R8 held low no pulse", pulses, 1);
    pin[1] = 1'b1; step(6);
    check("R8 rise no pulse", pulses, 1);
    pin[1] = 1'b0; step(6); pin[1] = 1'b1; step(6);
    check("R8 second fall", pulses, 2);
    check("R6 pin1 still undriven", pad_oe[1], 1'b0);
    wr(8'h20, 8'h80); pulses = 0;
    pin[1] = 1'b0; step(6); pin[1] = 1'b1; step(6);
    check("R9 mode10 ignored", pulses, 0);
    wr(8'h20, 8'h00);
    pin[1] = 1'b0; step(6); pin[1] = 1'b1; step(6);
    check("R9 mode00 ignored", pulses, 0);
  endtask

  task automatic t_strap();
    wr(8'h20, 8'h82);
    pin = 2'b01; step(4);
    strap = 1'b1; step(1); strap = 1'b0;
    check("R10 levels 01", bus_addr, {HI, 2'b01});
    pin = 2'b10; step(4);
    check("R10 holds until sample", bus_addr, {HI, 2'b01});
    strap = 1'b1; step(1); strap = 1'b0;
    check("R10 levels 10", bus_addr, {HI, 2'b10});
    wr(8'h20, 8'h43); pin = 2'b11; step(4);
    strap = 1'b1; step(1); strap = 1'b0;
    check("R10 pulled both zero", bus_addr, {HI, 2'b00});
    wr(8'h20, 8'h03); step(1);
    strap = 1'b1; step(1); strap = 1'b0;
    check("R10 pin1 mode00 level", bus_addr, {HI, 2'b10});
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_irq();
    t_conv();
    t_strap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule